// File: doc/BRIEF.md
# Don't-Care Expanding Hit List Reader

This block answers one lookup request at a time. A request carries a 14-bit identifier and a 2-bit wildcard code that says how many of the identifier's three lowest bits are free. The block turns the request into every identifier value that matches under that wildcard. For each value, in ascending order of its low bits, it fetches a hit count from one of eight count banks and a start pointer from a pointer memory. It then reads that many consecutive words from a hit list memory and streams them out.

All three memories sit outside the block. Each has a registered read port with one cycle of latency, and the block drives their enables and addresses. Every output hit is flagged when it is the last hit of its low-bit value. A pulse marks the end of the whole request, and a second flag joins that pulse when no hit at all was found. A further flag marks any hit whose address ran past the top of the hit list memory.

Top module: `dcHitReader`

## Requirements
- R1: `reqReady` is high only while the block is idle; a request is taken on a clock edge with `reqValid` and `reqReady` both high, and `reqReady` stays low until the end-of-request pulse.
- R2: With wildcard code `reqDc` = d (0..3), the low-bit values examined are exactly those i in 0..7 whose bits [2:d] equal those of `reqId[2:0]` (d=0: only `reqId[2:0]`; d=3: all eight).
- R3: The examined values are visited in ascending order of i; values that do not match produce no memory reads and no output.
- R4: For a matching i, count bank i alone is read (`bankRdEn` bit i, at most one bit high) at `bankRdAddr` = `reqId[13:3]`, and in the same cycle the pointer memory is read at `{reqId[13:3], i}`; bank i's data is `bankRdData[i*CNT_W +: CNT_W]`.
- R5: For a count c and pointer p, hit memory words at p+0 .. p+c-1 are read in that order, and each word appears on `hitData` with `hitValid` high one cycle after its read.
- R6: `hitLast` is high together with `hitValid` on the final hit of each low-bit value and on no other hit.
- R7: A low-bit value whose count is 0 produces no output hit.
- R8: `idLast` pulses for one cycle after the final examined value (i up to 7) is finished; the block is ready for a new request on the next cycle.
- R9: `empty` is high together with `idLast` when the request produced no hit, and low otherwise.
- R10: When p plus the offset exceeds 1023, the read address wraps to its low 10 bits and `hitOvf` is high with that hit; otherwise `hitOvf` is low.
- R11: During and right after reset, `reqReady` is high and `hitValid`, `idLast`, `empty` and all read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqId | input | ID_W | Requested identifier |
| reqDc | input | 2 | Number of low identifier bits to treat as wildcard |
| bankRdEn | output | 8 | Read enable, one bit per count bank |
| bankRdAddr | output | ID_W-3 | Shared count bank address (upper identifier bits) |
| bankRdData | input | 8*CNT_W | Count bank read data, bank i at slice i |
| ptrRdEn | output | 1 | Pointer memory read enable |
| ptrRdAddr | output | ID_W | Pointer memory address |
| ptrRdData | input | PTR_W | Pointer memory read data |
| hitRdEn | output | 1 | Hit list memory read enable |
| hitRdAddr | output | PTR_W | Hit list memory address |
| hitRdData | input | HIT_W | Hit list memory read data |
| hitValid | output | 1 | Output hit present |
| hitData | output | HIT_W | Output hit word |
| hitLast | output | 1 | Final hit of the current low-bit value |
| hitOvf | output | 1 | Hit address exceeded the memory range |
| idLast | output | 1 | Request finished |
| empty | output | 1 | Request produced no hit |

## Verification
The hardest state to reach is a hit list that crosses the top of the hit memory. That needs a large count and a pointer near address 1023 for the same identifier. The bench's memory models return counts and pointers as arithmetic functions of the address. One fixed identifier is given a count of 31 and a pointer of 1000, so its eighth bank wraps, and that identifier is swept under all four wildcard codes. An upper-bit value whose banks all hold zero drives the empty case, and a sweep of every low-bit value against every code covers the mask.

// File: rtl/dcHitReaderPkg.sv
package dcHitReaderPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_LOOKUP,
    S_STREAM,
    S_DONE
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;   // latch request, clear index
    logic probe;     // read count bank and pointer for current index
    logic loadList;  // capture count/pointer, issue first hit read
    logic nextHit;   // issue next hit read
    logic stepIdx;   // move to next low-bit value
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic maskHit;    // current index matches the request
    logic idxLast;    // current index is the final one
    logic cntZero;    // fetched count is zero
    logic hitLastNow; // hit on the output is the final one of its value
    logic anyHit;     // request produced at least one hit so far
  } dpStatus_t;

endpackage

// File: rtl/dcHitReaderCtrl.sv
module dcHitReaderCtrl
  import dcHitReaderPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dpStatus_t   st,
  output ctrlStrobe_t stb,
  output logic        reqReady,
  output logic        hitValid,
  output logic        idLast,
  output logic        empty
);

  rdState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    reqReady  = 1'b0;
    hitValid  = 1'b0;
    idLast    = 1'b0;
    empty     = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          stb.takeReq = 1'b1;
          stateNext   = S_SCAN;
        end
      end
      S_SCAN: begin
        if (st.maskHit) begin
          stb.probe = 1'b1;
          stateNext = S_LOOKUP;
        end else if (st.idxLast) begin
          stateNext = S_DONE;
        end else begin
          stb.stepIdx = 1'b1;
        end
      end
      S_LOOKUP: begin
        if (!st.cntZero) begin
          stb.loadList = 1'b1;
          stateNext    = S_STREAM;
        end else if (st.idxLast) begin
          stateNext = S_DONE;
        end else begin
          stb.stepIdx = 1'b1;
          stateNext   = S_SCAN;
        end
      end
      S_STREAM: begin
        hitValid = 1'b1;
        if (!st.hitLastNow) begin
          stb.nextHit = 1'b1;
        end else if (st.idxLast) begin
          stateNext = S_DONE;
        end else begin
          stb.stepIdx = 1'b1;
          stateNext   = S_SCAN;
        end
      end
      S_DONE: begin
        idLast    = 1'b1;
        empty     = !st.anyHit;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/dcHitReaderDp.sv
module dcHitReaderDp
  import dcHitReaderPkg::*;
#(
  parameter int ID_W  = 14,
  parameter int CNT_W = 5,
  parameter int PTR_W = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            stb,
  output dpStatus_t              st,
  input  logic [ID_W-1:0]        reqId,
  input  logic [1:0]             reqDc,
  output logic [7:0]             bankRdEn,
  output logic [ID_W-4:0]        bankRdAddr,
  input  logic [8*CNT_W-1:0]     bankRdData,
  output logic                   ptrRdEn,
  output logic [ID_W-1:0]        ptrRdAddr,
  input  logic [PTR_W-1:0]       ptrRdData,
  output logic                   hitRdEn,
  output logic [PTR_W-1:0]       hitRdAddr,
  output logic                   ovfFlag
);

  localparam int LOW_W = 3;
  localparam int BANKS = 1 << LOW_W;
  localparam int UP_W  = ID_W - LOW_W;

  logic [UP_W-1:0]  upReg;
  logic [BANKS-1:0] maskReg, maskNext;
  logic [LOW_W-1:0] idx;
  logic [CNT_W-1:0] cnt, off, cntSel;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W:0]   sum;
  logic             anyHit;

  // values whose kept low bits agree with the request
  logic [LOW_W-1:0] keepBits;
  assign keepBits = LOW_W'((LOW_W+1)'((1 << LOW_W) - 1) << reqDc);

  for (genvar gi = 0; gi < BANKS; gi++) begin : g_mask
    assign maskNext[gi] = ((LOW_W'(gi) ^ reqId[LOW_W-1:0]) & keepBits) == '0;
  end

  assign cntSel = bankRdData[idx*CNT_W +: CNT_W];
  assign sum    = stb.loadList ? {1'b0, ptrRdData}
                               : {1'b0, ptr} + (PTR_W+1)'(off) + (PTR_W+1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upReg   <= '0;
      maskReg <= '0;
      idx     <= '0;
      cnt     <= '0;
      off     <= '0;
      ptr     <= '0;
      anyHit  <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (stb.takeReq) begin
        upReg   <= reqId[ID_W-1:LOW_W];
        maskReg <= maskNext;
        idx     <= '0;
        anyHit  <= 1'b0;
      end
      if (stb.stepIdx) idx <= idx + 1'b1;
      if (stb.loadList) begin
        cnt    <= cntSel;
        ptr    <= ptrRdData;
        off    <= '0;
        anyHit <= 1'b1;
      end
      if (stb.nextHit) off <= off + 1'b1;
      if (stb.loadList || stb.nextHit) ovfFlag <= sum[PTR_W];
    end
  end

  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
    assign bankRdEn[gb] = stb.probe && (idx == LOW_W'(gb));
  end

  assign bankRdAddr = upReg;
  assign ptrRdEn    = stb.probe;
  assign ptrRdAddr  = {upReg, idx};
  assign hitRdEn    = stb.loadList | stb.nextHit;
  assign hitRdAddr  = sum[PTR_W-1:0];

  assign st.maskHit    = maskReg[idx];
  assign st.idxLast    = (idx == LOW_W'(BANKS - 1));
  assign st.cntZero    = (cntSel == '0);
  assign st.hitLastNow = (off == cnt - 1'b1);
  assign st.anyHit     = anyHit;

endmodule

// File: rtl/dcHitReader.sv
module dcHitReader
  import dcHitReaderPkg::*;
#(
  parameter int ID_W  = 14,
  parameter int CNT_W = 5,
  parameter int PTR_W = 10,
  parameter int HIT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [ID_W-1:0]      reqId,
  input  logic [1:0]           reqDc,
  output logic [7:0]           bankRdEn,
  output logic [ID_W-4:0]      bankRdAddr,
  input  logic [8*CNT_W-1:0]   bankRdData,
  output logic                 ptrRdEn,
  output logic [ID_W-1:0]      ptrRdAddr,
  input  logic [PTR_W-1:0]     ptrRdData,
  output logic                 hitRdEn,
  output logic [PTR_W-1:0]     hitRdAddr,
  input  logic [HIT_W-1:0]     hitRdData,
  output logic                 hitValid,
  output logic [HIT_W-1:0]     hitData,
  output logic                 hitLast,
  output logic                 hitOvf,
  output logic                 idLast,
  output logic                 empty
);

  ctrlStrobe_t stb;
  dpStatus_t   st;
  logic        ovfFlag;

  dcHitReaderCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .st       (st),
    .stb      (stb),
    .reqReady (reqReady),
    .hitValid (hitValid),
    .idLast   (idLast),
    .empty    (empty)
  );

  dcHitReaderDp #(.ID_W(ID_W), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .st         (st),
    .reqId      (reqId),
    .reqDc      (reqDc),
    .bankRdEn   (bankRdEn),
    .bankRdAddr (bankRdAddr),
    .bankRdData (bankRdData),
    .ptrRdEn    (ptrRdEn),
    .ptrRdAddr  (ptrRdAddr),
    .ptrRdData  (ptrRdData),
    .hitRdEn    (hitRdEn),
    .hitRdAddr  (hitRdAddr),
    .ovfFlag    (ovfFlag)
  );

  assign hitData = hitRdData;
  assign hitLast = hitValid & st.hitLastNow;
  assign hitOvf  = hitValid & ovfFlag;

endmodule

// File: rtl/dcHitReaderChecker.sv
module dcHitReaderChecker #(
  parameter int ID_W  = 14,
  parameter int PTR_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [7:0]      bankRdEn,
  input logic [ID_W-4:0] bankRdAddr,
  input logic            ptrRdEn,
  input logic [ID_W-1:0] ptrRdAddr,
  input logic            hitRdEn,
  input logic            hitValid,
  input logic            hitLast,
  input logic            hitOvf,
  input logic            idLast,
  input logic            empty
);

  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R1

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bankRdEn)); // R4

  AST_BANK_WITH_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (bankRdEn != 8'd0) |-> ptrRdEn); // R4

  AST_PTR_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ptrRdEn |-> bankRdEn[ptrRdAddr[2:0]] && ptrRdAddr[ID_W-1:3] == bankRdAddr); // R4

  AST_HIT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(hitRdEn)); // R5

  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    hitLast |-> hitValid); // R6

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    idLast |=> !idLast && reqReady); // R8

  AST_EMPTY_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> idLast && !hitValid); // R9

  AST_OVF_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    hitOvf |-> hitValid); // R10

endmodule

bind dcHitReader dcHitReaderChecker #(.ID_W(ID_W), .PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .bankRdEn   (bankRdEn),
  .bankRdAddr (bankRdAddr),
  .ptrRdEn    (ptrRdEn),
  .ptrRdAddr  (ptrRdAddr),
  .hitRdEn    (hitRdEn),
  .hitValid   (hitValid),
  .hitLast    (hitLast),
  .hitOvf     (hitOvf),
  .idLast     (idLast),
  .empty      (empty)
);

// File: tb/dcHitReader_bench.sv
`timescale 1ns/1ps
module dcHitReader_bench;

  localparam int ID_W = 14, CNT_W = 5, PTR_W = 10, HIT_W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic                rstN, reqValid, reqReady;
  logic [ID_W-1:0]     reqId;
  logic [1:0]          reqDc;
  logic [7:0]          bankRdEn;
  logic [ID_W-4:0]     bankRdAddr;
  logic [8*CNT_W-1:0]  bankRdData;
  logic                ptrRdEn;
  logic [ID_W-1:0]     ptrRdAddr;
  logic [PTR_W-1:0]    ptrRdData;
  logic                hitRdEn;
  logic [PTR_W-1:0]    hitRdAddr;
  logic [HIT_W-1:0]    hitRdData;
  logic                hitValid, hitLast, hitOvf, idLast, empty;
  logic [HIT_W-1:0]    hitData;

  dcHitReader #(.ID_W(ID_W), .CNT_W(CNT_W), .PTR_W(PTR_W), .HIT_W(HIT_W)) u_dcHitReader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqId(reqId), .reqDc(reqDc), .bankRdEn(bankRdEn), .bankRdAddr(bankRdAddr),
    .bankRdData(bankRdData), .ptrRdEn(ptrRdEn), .ptrRdAddr(ptrRdAddr),
    .ptrRdData(ptrRdData), .hitRdEn(hitRdEn), .hitRdAddr(hitRdAddr),
    .hitRdData(hitRdData), .hitValid(hitValid), .hitData(hitData),
    .hitLast(hitLast), .hitOvf(hitOvf), .idLast(idLast), .empty(empty)
  );

  int nTests = 0, nFail = 0;

  // memory contents as arithmetic functions of the address
  function automatic int cntOf(int b, int up);
    if (up % 16 == 5) return 0;
    if (up == 9 && b == 7) return 31;
    return (up * 7 + b * 3) % 6;
  endfunction

  function automatic int ptrOf(int a);
    if (a == (9 * 8 + 7)) return 1000;
    return (a * 37 + 5) % 1024;
  endfunction

  function automatic logic [HIT_W-1:0] hitOf(int a);
    logic [9:0] x;
    x = 10'(a);
    return {6'h2A, x, x ^ 10'h155, 6'h15};
  endfunction

  // registered-read memory models, one cycle latency
  always_ff @(posedge clk) begin
    for (int b = 0; b < 8; b++)
      if (bankRdEn[b]) bankRdData[b*CNT_W +: CNT_W] <= CNT_W'(cntOf(b, int'(bankRdAddr)));
    if (ptrRdEn) ptrRdData <= PTR_W'(ptrOf(int'(ptrRdAddr)));
    if (hitRdEn) hitRdData <= hitOf(int'(hitRdAddr));
  end

  logic [HIT_W-1:0] expData [0:255];
  logic             expLast [0:255];
  logic             expOvf  [0:255];

  task automatic runReq(input logic [ID_W-1:0] id, input logic [1:0] dc);
    int expN, k, up;
    logic done, busyBad;
    expN = 0;
    up   = int'(id[ID_W-1:3]);
    for (int i = 0; i < 8; i++) begin
      if (((i ^ int'(id[2:0])) & ((7 << dc) & 7)) == 0) begin      // R2, R3 order
        int c, p;
        c = cntOf(i, up);
        p = ptrOf(up * 8 + i);                                     // R4
        for (int o = 0; o < c; o++) begin                          // R5, R7
          expData[expN] = hitOf((p + o) % 1024);
          expLast[expN] = (o == c - 1);                            // R6
          expOvf[expN]  = (p + o) > 1023;                          // R10
          expN++;
        end
      end
    end
    @(negedge clk);
    nTests++;
    if (!reqReady) begin
      nFail++;
      $display("FAIL R8: reqReady=%0b expected 1 before request id=%0h", reqReady, id);
    end
    reqValid = 1'b1; reqId = id; reqDc = dc;
    @(negedge clk);
    reqValid = 1'b0;
    reqId = ~id; reqDc = ~dc;   // changes while busy must not matter
    k = 0; done = 1'b0; busyBad = 1'b0;
    for (int g = 0; g < 2000 && !done; g++) begin
      if (reqReady) busyBad = 1'b1;
      if (hitValid) begin
        nTests++;
        if (k >= expN) begin
          nFail++;
          $display("FAIL R5: extra hit %0h, expected only %0d hits (id=%0h dc=%0d)", hitData, expN, id, dc);
        end else if (hitData !== expData[k] || hitLast !== expLast[k] || hitOvf !== expOvf[k]) begin
          nFail++;
          $display("FAIL R5/R6/R10: hit %0d data=%0h last=%0b ovf=%0b, expected %0h %0b %0b (id=%0h dc=%0d)",
                   k, hitData, hitLast, hitOvf, expData[k], expLast[k], expOvf[k], id, dc);
        end
        k++;
      end
      if (idLast) begin
        done = 1'b1;
        nTests++;
        if (k != expN) begin
          nFail++;
          $display("FAIL R2/R7: %0d hits seen, expected %0d (id=%0h dc=%0d)", k, expN, id, dc);
        end
        nTests++;
        if (empty !== (expN == 0)) begin
          nFail++;
          $display("FAIL R9: empty=%0b expected %0b (id=%0h dc=%0d)", empty, expN == 0, id, dc);
        end
      end
      @(negedge clk);
    end
    nTests++;
    if (!done) begin
      nFail++;
      $display("FAIL R8: idLast=0 expected 1 within 2000 cycles (id=%0h dc=%0d)", id, dc);
    end
    nTests++;
    if (busyBad) begin
      nFail++;
      $display("FAIL R1: reqReady=1 expected 0 while busy (id=%0h dc=%0d)", id, dc);
    end
  endtask

  task automatic checkIdle(input string tag);
    nTests++;
    if (reqReady !== 1'b1 || hitValid !== 1'b0 || idLast !== 1'b0 || empty !== 1'b0 ||
        bankRdEn !== 8'd0 || ptrRdEn !== 1'b0 || hitRdEn !== 1'b0) begin
      nFail++;
      $display("FAIL R11 (%s): ready=%0b valid=%0b idLast=%0b empty=%0b banks=%0h ptr=%0b hit=%0b, expected 1 0 0 0 0 0 0",
               tag, reqReady, hitValid, idLast, empty, bankRdEn, ptrRdEn, hitRdEn);
    end
  endtask

  initial begin
    int ups [0:7];
    ups = '{0, 1, 5, 9, 21, 37, 100, 2047};
    rstN = 1'b0; reqValid = 1'b0; reqId = '0; reqDc = '0;
    repeat (3) @(negedge clk);
    checkIdle("in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("after reset");
    for (int d = 0; d < 4; d++)
      for (int u = 0; u < 8; u++)
        for (int lo = 0; lo < 8; lo++)
          runReq(ID_W'(ups[u] * 8 + lo), 2'(d));
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule